// File: doc/BRIEF.md
# SPI Slave Port with Ordered Flag Clearing

This block is an SPI slave for an 8-bit CPU. A CPU bus reaches two registers, a data register at address 1 and a status register at address 0. The serial side takes a clock, a data input from the master, an active-low select, and returns serial data with an output enable for an external tristate buffer. Each byte moves in SPI mode 0, most significant bit first. The byte arriving from the master lands in the shift register. The byte that was in the shift register goes out to the master at the same time.

Two flags live in the status register. A completion flag rises when a full byte has arrived. A collision flag rises when the CPU writes the data register during a byte. Software clears the flags with a status read followed by a data read. A byte left in the shift register with no reload goes back out on the next transfer. Serial inputs are synchronised into the system clock with two flops before their edges are detected.

Top module: `spi_slave_port`

## Requirements
- R1: Each byte shifts MSB first in mode 0: the data input is captured on the synchronised rising clock edge, and the output bit changes on the falling edge, so the master receives the preloaded byte MSB first.
- R2: The completion flag, status bit 7, rises after the eighth rising serial-clock edge of a byte, and the received byte is then readable at address 1.
- R3: A status read (address 0) taken while a flag is set, followed directly by a data read (address 1), clears the flags. A data read followed by a status read clears nothing.
- R4: A data-register write clears no collision flag, and it cancels a clearing sequence armed by an earlier status read.
- R5: If the CPU writes no new data after a transfer, the next transfer sends the byte just received back out.
- R6: The output enable is low while select is high, and select held high through reset keeps the slave disabled with the enable low.
- R7: A data write while select is low and the bit count is nonzero sets the collision flag, status bit 6. The written byte is discarded and the shift register keeps its contents.
- R8: Raising select in the middle of a byte resets the bit count and sets no flag. The next full byte is received intact.
- R9: If only the collision flag was set when the status read armed the sequence, the following data read clears the collision flag alone, and status bits 5..0 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cs_i | input | 1 | Register access strobe, one cycle per access |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 1 | 0 = status, 1 = data |
| cpu_wdata_i | input | W | Write data |
| cpu_rdata_o | output | W | Read data for the addressed register |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| ss_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Enable for the external MISO tristate buffer |

## Verification
Serial inputs pass two synchroniser flops and one edge register, so each effect shows up three system clocks after the pin changes: the flags after the eighth rising edge, the output bit after a falling edge, and the enable after select moves. The bench holds every serial-clock phase for eight system clocks, reads MISO just before each rising edge, and reads registers only after the closing falling edge has settled. Register reads are combinational and are sampled one time unit after the strobe is applied, before the edge that commits the access. A flag change caused by that access is observed on the next read.

// File: rtl/spi_slave_port.sv
module spi_slave_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_cs_i,
  input  logic         cpu_we_i,
  input  logic         cpu_addr_i,
  input  logic [W-1:0] cpu_wdata_i,
  output logic [W-1:0] cpu_rdata_o,
  input  logic         sck_i,
  input  logic         mosi_i,
  input  logic         ss_n_i,
  output logic         miso_o,
  output logic         miso_oe_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2:0]    sck_p;
  logic [1:0]    ss_p, mosi_p;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q, rx_q;
  logic          miso_q, spif_q, wcol_q, arm_q, arm_f_q;

  wire active = ~ss_p[1];
  wire rise   = sck_p[1] & ~sck_p[2];
  wire fall   = ~sck_p[1] & sck_p[2];
  wire busy   = active && cnt_q != '0;
  wire last   = rise && active && cnt_q == LAST;
  wire st_rd  = cpu_cs_i & ~cpu_we_i & ~cpu_addr_i;
  wire dt_rd  = cpu_cs_i & ~cpu_we_i & cpu_addr_i;
  wire dt_wr  = cpu_cs_i & cpu_we_i & cpu_addr_i;
  wire wr_ok  = dt_wr & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p  <= '0;
      ss_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck_i};
      ss_p   <= {ss_p[0], ss_n_i};
      mosi_p <= {mosi_p[0], mosi_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      if (!active)   cnt_q <= '0;
      else if (rise) cnt_q <= last ? '0 : cnt_q + 1'b1;

      if (wr_ok)               sh_q <= cpu_wdata_i;
      else if (rise && active) sh_q <= {sh_q[W-2:0], mosi_p[1]};

      if (last) rx_q <= {sh_q[W-2:0], mosi_p[1]};

      if (wr_ok)                miso_q <= cpu_wdata_i[W-1];
      else if (!active || fall) miso_q <= sh_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif_q  <= 1'b0;
      wcol_q  <= 1'b0;
      arm_q   <= 1'b0;
      arm_f_q <= 1'b0;
    end else begin
      if (last)                          spif_q <= 1'b1;
      else if (dt_rd && arm_q && arm_f_q) spif_q <= 1'b0;

      if (dt_wr && busy)       wcol_q <= 1'b1;
      else if (dt_rd && arm_q) wcol_q <= 1'b0;

      if (cpu_cs_i) begin
        arm_q   <= st_rd && (spif_q || wcol_q);
        arm_f_q <= spif_q;
      end
    end
  end

  assign cpu_rdata_o = cpu_addr_i ? rx_q : {spif_q, wcol_q, {(W-2){1'b0}}};
  assign miso_oe_o   = active;
  assign miso_o      = miso_q & active;

  // R2
  spif_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> spif_q);
  // R3
  spif_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spif_q && !dt_rd |=> spif_q);
  // R4
  wcol_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_q && dt_wr |=> wcol_q);
  // R7
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dt_wr && busy |=> wcol_q && $stable(sh_q));
  // R6
  oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ss_n_i, 2) |-> !miso_oe_o);
  // R8
  no_spurious_spif_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spif_q && !last |=> !spif_q);
endmodule

// File: tb/test_spi_slave_port.sv
module test_spi_slave_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic       clk = 0, rst_n = 0;
  logic       cs = 0, we = 0, addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       sck = 0, mosi = 0, ss_n = 1;
  logic       miso, miso_oe;

  int compared = 0, mismatched = 0;
  logic [7:0] cap = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       byte_ev;
  bit         finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_slave_port #(.W(8)) i_spi_slave_port (
    .clk(clk), .rst_n(rst_n), .cpu_cs_i(cs), .cpu_we_i(we), .cpu_addr_i(addr),
    .cpu_wdata_i(wdata), .cpu_rdata_o(rdata), .sck_i(sck), .mosi_i(mosi),
    .ss_n_i(ss_n), .miso_o(miso), .miso_oe_o(miso_oe));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  initial forever begin
    @(byte_ev);
    if (exp_q.size() == 0) chk("R1 unexpected byte", cap, 8'hxx);
    else chk(tag_q.pop_front(), cap, exp_q.pop_front());
  end

  task automatic expect_byte(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic cpu_rd(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); cs = 0;
  endtask

  task automatic cpu_wr(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic sel(input logic v);
    @(negedge clk); ss_n = v;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bits(input logic [7:0] v, input int from, input int to);
    for (int i = from; i < to; i++) begin
      @(negedge clk); mosi = v[7-i];
      repeat (HALF) @(negedge clk);
      cap = {cap[6:0], miso};
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic end_byte();
    -> byte_ev;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    chk("R6 oe low in reset", {7'b0, miso_oe}, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cpu_rd(0, d); chk("R2 status after reset", d, 8'h00);
    chk("R6 oe low idle", {7'b0, miso_oe}, 8'h00);

    cpu_wr(1, 8'hA5);
    sel(0);
    chk("R6 oe high when selected", {7'b0, miso_oe}, 8'h01);
    expect_byte("R1 preload out", 8'hA5);
    bits(8'h3C, 0, 8); end_byte();
    cpu_rd(0, d); chk("R2 done flag", d, 8'h80);
    cpu_rd(1, d); chk("R2 rx byte", d, 8'h3C);
    cpu_rd(0, d); chk("R3 cleared", d, 8'h00);

    expect_byte("R5 echo", 8'h3C);
    bits(8'h81, 0, 8); end_byte();
    cpu_rd(1, d); chk("R2 rx byte 2", d, 8'h81);
    cpu_rd(0, d); chk("R3 wrong order keeps flag", d, 8'h80);
    cpu_rd(1, d);
    cpu_rd(0, d); chk("R3 ordered clear", d, 8'h00);

    bits(8'hC3, 0, 3);
    cpu_wr(1, 8'hFF);
    cpu_rd(0, d); chk("R7 collision flag", d, 8'h40);
    cpu_rd(1, d);
    cpu_rd(0, d); chk("R9 collision-only clear", d, 8'h00);
    expect_byte("R7 write discarded", 8'h81);
    bits(8'hC3, 3, 8); end_byte();
    cpu_rd(0, d); chk("R2 done after collision", d, 8'h80);
    cpu_rd(1, d); chk("R2 rx C3", d, 8'hC3);

    bits(8'h66, 0, 2);
    cpu_wr(1, 8'h11);
    cpu_rd(0, d);
    cpu_wr(1, 8'h22);
    cpu_rd(1, d);
    cpu_rd(0, d); chk("R4 write keeps collision", d, 8'h40);
    expect_byte("R5 echo after discard", 8'hC3);
    bits(8'h66, 2, 8); end_byte();
    cpu_rd(0, d); chk("R2 both flags", d, 8'hC0);
    cpu_rd(1, d); chk("R2 rx 66", d, 8'h66);
    cpu_rd(0, d); chk("R3 both cleared", d, 8'h00);

    bits(8'hF0, 0, 4);
    sel(1);
    chk("R6 oe low after deselect", {7'b0, miso_oe}, 8'h00);
    cpu_rd(0, d); chk("R8 no flag on partial", d, 8'h00);
    cpu_wr(1, 8'h5A);
    sel(0);
    expect_byte("R1 reload out", 8'h5A);
    bits(8'h99, 0, 8); end_byte();
    cpu_rd(0, d); chk("R8 full byte after abort", d, 8'h80);
    cpu_rd(1, d); chk("R8 rx intact", d, 8'h99);
    sel(1);

    if (exp_q.size() != 0) chk("R1 bytes missing", 8'(exp_q.size()), 8'h00);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule